// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds a small slice of a type-0 PCI configuration header for a single-function serial-bus controller. Software reaches it through a simple register port. The port carries a byte address, four byte enables and 32-bit data. Only dword-aligned accesses are decoded, so address bits 1:0 are ignored. Reads are registered, so the data appears on the cycle after the read strobe.

Six status flags record events. Each flag is set by a one-cycle pulse from the surrounding bus logic and stays set until software writes a one to its bit. One of these flags, data parity detected, can only be set while the parity-error-response enable in the command register is on. That enable is the only writable command bit, and it is also driven out to the parity logic. The rest of the header region is read-only: identification and class constants, the cache line size, the header type, BIST and the DEVSEL timing code. The one exception is the latency timer, which is writable in its upper nibble only.

Top module: `cfg_header_regs`

## Requirements
- R1: After a synchronous reset, all six status flags read 0, command bit 6 reads 0, `perr_en` is 0 and the latency timer reads 50h.
- R2: A pulse on `ev_pulse[k]` sets a flag that then stays set. Bit 0 sets dword 04h bit 24 (data parity detected). Bits 1 to 5 set dword 04h bits 27 to 31 in that order: signaled target abort, received target abort, received master abort, signaled system error, detected parity error.
- R3: A write to dword 04h with `be[3]` high clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged, and every flag is unchanged when `be[3]` is low.
- R4: When a clearing write and an event hit the same flag in the same cycle, the flag ends up set.
- R5: `ev_pulse[0]` sets the data-parity flag only while command bit 6 is 1. With the bit at 0, the pulse has no effect.
- R6: Dword 04h bit 6 is read/write through lane 0 and drives `perr_en`. Bits 15:0 other than bit 6 read 0.
- R7: Dword 04h bits 26:25 (DEVSEL timing) always read 01b, meaning medium (00 fast, 01 medium, 10 slow, 11 reserved). Bits 23:16 read 0. Writes change neither field.
- R8: Dword 08h always reads 0C001003h: base class 0Ch, sub class 00h, programming interface 10h, revision 03h. Writes do not change it.
- R9: Dword 0Ch reads {BIST 00h, header type 00h, latency timer, cache line 00h}, with the latency timer in bits 15:8. A write with `be[1]` high loads bits 15:12 of the timer. Bits 11:8 always read 0.
- R10: A write changes only the byte lanes whose enable is high.
- R11: Reads of any dword other than 04h, 08h and 0Ch return 0.
- R12: `rdata` takes the addressed value on the clock edge that samples `rd_en` high, using state from before that edge. It holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address; bits 7:2 select the dword |
| be | input | 4 | Byte enables for the write lanes |
| wdata | input | 32 | Write data |
| ev_pulse | input | 6 | One-cycle event strobes, mapped as in R2 |
| rdata | output | 32 | Registered read data |
| perr_en | output | 1 | Parity-error-response enable (command bit 6) |

## Verification
The bench aims at the following corner cases:
- **Event and clear in the same cycle.** A design that lets the clear win drops an event.
- **Data-parity pulse while the enable is off.** A design that ignores the gate sets a flag that should stay clear.
- **Clearing writes with the top byte lane disabled.** A design that ignores the enable wipes flags it should not touch.
- **Writes to the forced-zero timer nibble and to the read-only DEVSEL, class and reserved fields.** A faulty design lets these bits change.

Random mixes of events, partial writes and reads across all 64 dwords are compared against a bench model of the flags, the enable and the timer. That comparison also catches a flag mapped to the wrong bit and a read that returns post-edge state.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int NUM_EVT = 6;
  localparam int DW_IDX_W = 6;

  localparam logic [DW_IDX_W-1:0] DW_CMDSTAT = 6'd1;
  localparam logic [DW_IDX_W-1:0] DW_CLASS   = 6'd2;
  localparam logic [DW_IDX_W-1:0] DW_MISC    = 6'd3;

  // dword bit position of the status flag set by event k
  function automatic int flag_pos(input int k);
    return (k == 0) ? 24 : (26 + k);
  endfunction

  typedef struct packed {
    logic [7:0] base_cls;
    logic [7:0] sub_cls;
    logic [7:0] prog_if;
    logic [7:0] rev;
  } id_word_t;
endpackage

// File: rtl/cfg_sticky_flags.sv
module cfg_sticky_flags #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] gate_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic set_k;
    assign set_k = ev_i[k] & gate_i[k];

    always_ff @(posedge clk) begin
      if (rst)        flags_o[k] <= 1'b0;
      else if (set_k) flags_o[k] <= 1'b1;   // event beats clear (R4)
      else if (clr_i[k]) flags_o[k] <= 1'b0;
    end

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
      (ev_i[k] && gate_i[k]) |=> flags_o[k]);
    p_event_wins_r4: assert property (@(posedge clk) disable iff (rst)
      (ev_i[k] && gate_i[k] && clr_i[k]) |=> flags_o[k]);
    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
      (flags_o[k] && !clr_i[k]) |=> flags_o[k]);
    p_gated_r5: assert property (@(posedge clk) disable iff (rst)
      (!flags_o[k] && !gate_i[k]) |=> !flags_o[k]);
  end
endmodule

// File: rtl/cfg_masked_reg.sv
module cfg_masked_reg #(
  parameter int         W        = 8,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [W-1:0] RO_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] WR_MASK = ~RO_MASK;

  always_ff @(posedge clk) begin
    if (rst)       q_o <= RST_VAL & WR_MASK;
    else if (we_i) q_o <= wd_i & WR_MASK;
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port
  import cfg_hdr_pkg::*;
#(
  parameter id_word_t ID_WORD = '{8'h0C, 8'h00, 8'h10, 8'h03},
  parameter logic [1:0] DEVSEL_CODE = 2'b01,
  parameter logic [7:0] CACHE_LINE = 8'h00,
  parameter logic [7:0] HDR_TYPE = 8'h00,
  parameter logic [7:0] BIST_VAL = 8'h00
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [DW_IDX_W-1:0] dw_idx,
  input  logic [15:0]         cmd_word,
  input  logic [15:0]         stat_word,
  input  logic [7:0]          lat_val,
  output logic [31:0]         rdata
);
  logic [31:0] sel;

  always_comb begin
    unique case (dw_idx)
      DW_CMDSTAT: sel = {stat_word, cmd_word};
      DW_CLASS:   sel = ID_WORD;
      DW_MISC:    sel = {BIST_VAL, HDR_TYPE, lat_val, CACHE_LINE};
      default:    sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

  p_devsel_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && dw_idx == DW_CMDSTAT) |=> (rdata[26:25] == DEVSEL_CODE && rdata[23:16] == 8'h00));
  p_lat_nibble_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && dw_idx == DW_MISC) |=> (rdata[11:8] == 4'h0));
  p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && dw_idx != DW_CMDSTAT && dw_idx != DW_CLASS && dw_idx != DW_MISC) |=> (rdata == 32'h0));
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
  import cfg_hdr_pkg::*;
#(
  parameter logic [7:0] LAT_RESET = 8'h50,
  parameter logic [7:0] LAT_RO    = 8'h0F,
  parameter logic [7:0] CMD_RO    = 8'hBF,
  parameter logic [1:0] DEVSEL    = 2'b01
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [7:0]          addr,
  input  logic [3:0]          be,
  input  logic [31:0]         wdata,
  input  logic [NUM_EVT-1:0]  ev_pulse,
  output logic [31:0]         rdata,
  output logic                perr_en
);
  logic [DW_IDX_W-1:0] dw;
  logic                wr_cs, wr_misc;
  logic [NUM_EVT-1:0]  clr, gate, flags;
  logic [7:0]          cmd_lo, lat;
  logic [15:0]         stat_word;

  assign dw      = addr[7:2];
  assign wr_cs   = wr_en && (dw == DW_CMDSTAT);
  assign wr_misc = wr_en && (dw == DW_MISC);

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_map
    localparam int P = flag_pos(k);
    assign clr[k]  = wr_cs && be[3] && wdata[P];
    assign gate[k] = (k == 0) ? cmd_lo[6] : 1'b1;
  end

  always_comb begin
    stat_word = '0;
    stat_word[10:9] = DEVSEL;
    for (int k = 0; k < NUM_EVT; k++) stat_word[flag_pos(k) - 16] = flags[k];
  end

  cfg_sticky_flags #(.N(NUM_EVT)) u_flags (
    .clk(clk), .rst(rst), .ev_i(ev_pulse), .gate_i(gate),
    .clr_i(clr), .flags_o(flags)
  );

  cfg_masked_reg #(.W(8), .RST_VAL(8'h00), .RO_MASK(CMD_RO)) u_cmd (
    .clk(clk), .rst(rst), .we_i(wr_cs && be[0]), .wd_i(wdata[7:0]), .q_o(cmd_lo)
  );

  cfg_masked_reg #(.W(8), .RST_VAL(LAT_RESET), .RO_MASK(LAT_RO)) u_lat (
    .clk(clk), .rst(rst), .we_i(wr_misc && be[1]), .wd_i(wdata[15:8]), .q_o(lat)
  );

  cfg_read_port #(.DEVSEL_CODE(DEVSEL)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .dw_idx(dw),
    .cmd_word({8'h00, cmd_lo}), .stat_word(stat_word), .lat_val(lat), .rdata(rdata)
  );

  assign perr_en = cmd_lo[6];

  p_perr_follows_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_cs && be[0]) |=> (perr_en == $past(wdata[6])));
  p_perr_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !(wr_cs && be[0]) |=> $stable(perr_en));
endmodule

// File: tb/test_cfg_header_regs.sv
module test_cfg_header_regs;
  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0;
  logic [5:0] ev_pulse = '0;
  logic [31:0] rdata;
  logic perr_en;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [5:0] m_flag;
  logic m_cmd6;
  logic [7:0] m_lat;
  logic [31:0] exp_rd;

  always #10 clk = ~clk;

  cfg_header_regs i_cfg_header_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .be(be),
    .wdata(wdata), .ev_pulse(ev_pulse), .rdata(rdata), .perr_en(perr_en)
  );

  function automatic int fpos(input int k);
    return (k == 0) ? 24 : 26 + k;
  endfunction

  function automatic logic [31:0] model_read(input logic [5:0] dwi);
    logic [31:0] v;
    v = '0;
    case (dwi)
      6'd1: begin
        v[25] = 1'b1;
        v[6] = m_cmd6;
        for (int k = 0; k < 6; k++) v[fpos(k)] = m_flag[k];
      end
      6'd2: v = 32'h0C001003;
      6'd3: v = {16'h0000, m_lat, 8'h00};
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle; update model; check read and perr_en after the edge
  task automatic step(input bit wr, input bit rd, input logic [7:0] a, input logic [3:0] b,
                      input logic [31:0] d, input logic [5:0] ev, input string req);
    logic [5:0] nf;
    @(negedge clk);
    wr_en = wr; rd_en = rd; addr = a; be = b; wdata = d; ev_pulse = ev;
    exp_rd = rd ? model_read(a[7:2]) : rdata;
    for (int k = 0; k < 6; k++) begin
      bit setk, clrk;
      setk = ev[k] && (k != 0 || m_cmd6);
      clrk = wr && a[7:2] == 6'd1 && b[3] && d[fpos(k)];
      nf[k] = setk | (m_flag[k] & ~clrk);
    end
    m_flag = nf;
    if (wr && a[7:2] == 6'd1 && b[0]) m_cmd6 = d[6];
    if (wr && a[7:2] == 6'd3 && b[1]) m_lat = {d[15:12], 4'h0};
    @(posedge clk); #1;
    check(req, rdata, exp_rd);
    check("R6 perr_en", {31'd0, perr_en}, {31'd0, m_cmd6});
    wr_en = 0; rd_en = 0; ev_pulse = '0;
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    step(0, 1, a, 4'h0, 32'h0, 6'h0, req);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_flag = '0; m_cmd6 = 0; m_lat = 8'h50;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset values
    rd(8'h04, "R1 status/cmd reset");
    rd(8'h0C, "R1 latency reset");
    check("R1 perr_en reset", {31'd0, perr_en}, 32'd0);

    // R2 each event sets its flag, stays set; R3 clear with 1
    for (int k = 1; k < 6; k++) begin
      step(0, 0, 8'h04, 4'h0, 0, 6'(1 << k), "R2 pulse");
      step(0, 0, 8'h04, 4'h0, 0, 6'h0, "R2 idle");
      rd(8'h04, "R2 flag set and held");
      step(1, 0, 8'h04, 4'hF, 32'h0, 6'h0, "R3 write zeros");
      rd(8'h04, "R3 zero write keeps flag");
      step(1, 0, 8'h04, 4'h7, 32'hFFFF_0000, 6'h0, "R3 be3 low");
      rd(8'h04, "R3 be3 low keeps flag");
      step(1, 0, 8'h04, 4'h8, 32'(1) << fpos(k), 6'h0, "R3 clear");
      rd(8'h04, "R3 flag cleared");
    end

    // R5 gating of data-parity flag
    step(0, 0, 8'h04, 4'h0, 0, 6'h01, "R5 gated pulse");
    rd(8'h04, "R5 blocked while bit6=0");
    step(1, 0, 8'h04, 4'h1, 32'h40, 6'h0, "R6 set cmd6");
    rd(8'h04, "R6 cmd bit6 readback");
    step(0, 0, 8'h04, 4'h0, 0, 6'h01, "R5 enabled pulse");
    rd(8'h04, "R5 set while bit6=1");

    // R4 event beats simultaneous clear
    step(1, 0, 8'h04, 4'h8, 32'hFFFF_FFFF & ~32'h0000_00FF, 6'h3F, "R4 clear+event");
    rd(8'h04, "R4 event wins");
    step(1, 0, 8'h04, 4'h9, 32'hFF00_0040, 6'h0, "R3 clear all");
    rd(8'h04, "R3 all cleared");

    // R7/R8/R9 read-only fields and latency nibble
    step(1, 0, 8'h04, 4'hF, 32'h0600_FFBF, 6'h0, "R7 write ro");
    rd(8'h04, "R7 devsel/reserved/cmd ro");
    step(1, 0, 8'h08, 4'hF, 32'hFFFF_FFFF, 6'h0, "R8 write id");
    rd(8'h08, "R8 class/revision");
    step(1, 0, 8'h0C, 4'hF, 32'hFFFF_FFFF, 6'h0, "R9 write misc");
    rd(8'h0C, "R9 latency F0");
    step(1, 0, 8'h0C, 4'hD, 32'h0000_3300, 6'h0, "R10 be1 low");
    rd(8'h0C, "R10 lane unchanged");

    // R11 unmapped and R12 hold
    rd(8'h00, "R11 dword 00");
    rd(8'hFC, "R11 dword FC");
    rd(8'h08, "R12 read");
    step(1, 0, 8'h0C, 4'h2, 32'h0000_A000, 6'h3F, "R12 hold while idle");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      bit w = r[0];
      bit rr = r[1] | r[2];
      logic [7:0] a = r[3] ? {2'b00, 4'd0, 2'b00} | 8'(( $urandom % 4) << 2) : 8'(($urandom % 64) << 2) | 8'(r[9:8]);
      logic [5:0] ev = ($urandom % 4 == 0) ? 6'($urandom) : 6'h0;
      step(w, rr, a, 4'($urandom), $urandom, ev, "R2-R12 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule